// File: doc/BRIEF.md
# Edge/Level Interrupt Request Servicer

This block sits between a set of interrupt input lines and an interrupt delivery fabric. Each pin has its own routing entry, supplied as inputs: vector, destination, destination mode, delivery mode, trigger kind and mask. Assert and deassert events from the sources update per-pin request bits. The block decides which requests become delivery messages and which are merged into a request that is already pending. Edge pins merge on a request bit that is still set. Level pins merge while an earlier delivery is awaiting end-of-interrupt, which is tracked in a per-pin remote-pending bit.

An end-of-interrupt (EOI) carries a vector and is broadcast to all pins. For matching pins it releases the remote-pending bit and re-issues a level request that is still held. If a pin is redelivered on EOI too many times in a row, the next redelivery is handed to a single retry timer. When that timer expires, every waiting level pin is resent. A readout vector gives the request bits with already-delivered edges removed, for state capture.

The control path is a two-state machine:
- **S_IDLE**: picks the lowest-numbered pin that needs service. A masked pick is dropped and the machine stays in S_IDLE. An unmasked pick captures the routing fields and moves to S_SEND.
- **S_SEND**: holds the message valid. When the fabric accepts it, the machine returns to S_IDLE.

Top module: `irq_servicer`

## Requirements
- R1: A deassert event (`line_lo` bit) clears that pin's request bit, so it disappears from `saved_irr`.
- R2: An assert event on an edge pin (`trig_level` bit 0) sets the request bit and clears the delivered bit. If the request bit was already set, `coalesced` pulses for that pin and no message is issued.
- R3: An assert event on a level pin (`trig_level` bit 1) whose remote-pending bit is set sets the request bit, pulses `coalesced`, and issues no message.
- R4: A pin picked for service while `pin_mask` is 1 is never sent. `mask_drop` pulses for that pin one cycle after the pick.
- R5: An accepted edge message sets the pin's delivered bit. An accepted level message sets remote-pending only when `msg_hits` is nonzero.
- R6: An EOI whose vector matches leaves remote-pending unchanged if it is marked edge (`eoi_level`=0) or if `directed_eoi` is 1.
- R7: A level-marked, non-directed EOI clears remote-pending on every pin with a matching vector. If that pin is unmasked and still requested, its successive-EOI count increments and the pin is redelivered. Otherwise the count returns to zero.
- R8: The EOI that would bring the count to `STORM_LIMIT` delivers nothing at once. It zeroes the count and arms the retry timer, if the timer is not already running.
- R9: `RETRY_CYCLES` cycles after arming, every level pin with its request bit set and remote-pending clear is queued for delivery.
- R10: `saved_irr` equals the request bits with the delivered-edge bits masked off.
- R11: When several pins await service, the lowest-numbered pin is sent first.
- R12: Only one message is outstanding. `msg_valid` and its fields stay stable until `msg_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_hi | input | NPIN | Per-pin assert event |
| line_lo | input | NPIN | Per-pin deassert event |
| trig_level | input | NPIN | 1 = level pin, 0 = edge pin |
| pin_mask | input | NPIN | 1 = pin masked |
| pin_dest_mode | input | NPIN | Destination mode bit per pin |
| pin_vector | input | NPIN*VEC_W | Vector per pin, pin p at bits [p*VEC_W +: VEC_W] |
| pin_dest | input | NPIN*DEST_W | Destination per pin |
| pin_dlv_mode | input | NPIN*3 | Delivery mode per pin |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector being ended |
| eoi_level | input | 1 | EOI marked level (1) or edge (0) |
| directed_eoi | input | 1 | Directed-EOI mode enabled |
| msg_valid | output | 1 | Delivery message valid |
| msg_pin | output | PIN_W | Source pin of message |
| msg_vector | output | VEC_W | Message vector |
| msg_dest | output | DEST_W | Message destination |
| msg_dest_mode | output | 1 | Message destination mode |
| msg_dlv_mode | output | 3 | Message delivery mode |
| msg_level | output | 1 | Message trigger kind, 1 = level |
| msg_accept | input | 1 | Fabric accepted message |
| msg_hits | input | HIT_W | Number of destinations reached |
| coalesced | output | NPIN | Pulse: assert event merged |
| mask_drop | output | NPIN | Pulse: masked pin dropped at service |
| saved_irr | output | NPIN | Request bits minus delivered edges |

## Verification
The bench builds the block with `STORM_LIMIT`=4 and `RETRY_CYCLES`=20, instead of the defaults of 10000 and two million cycles. With these values a handful of EOIs reaches the storm threshold, and the deferred retry arrives in a few dozen cycles. The tests can therefore confirm both the silent window and the late redelivery. Eight pins with two level pins and one masked pin cover every merge rule, the zero-hit acceptance case and lowest-pin ordering.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_SEND = 1'b1
    } srv_state_t;
endpackage

// File: rtl/irqs_pin_slice.sv
module irqs_pin_slice #(
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_hi,
    input  logic             line_lo,
    input  logic             lvl_mode,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic             directed_eoi,
    input  logic             served,
    input  logic             acc_done,
    input  logic             acc_ok,
    input  logic             retry_fire,
    output logic             irr,
    output logic             delivered,
    output logic             remote,
    output logic             pend,
    output logic             coalesced,
    output logic             defer
);
    localparam int CNT_W = $clog2(STORM_LIMIT + 1);

    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic irr_n, del_n, rem_n, pend_n, coal_n;

    always_comb begin
        irr_n  = irr;
        del_n  = delivered;
        rem_n  = remote;
        pend_n = pend;
        cnt_n  = cnt_q;
        coal_n = 1'b0;
        defer  = 1'b0;
        if (served) pend_n = 1'b0;
        if (acc_done) begin
            if (!lvl_mode)   del_n = 1'b1;
            else if (acc_ok) rem_n = 1'b1;
        end
        if (eoi_valid && eoi_vector == vector && eoi_level && !directed_eoi) begin
            rem_n = 1'b0;
            if (!masked && irr) begin
                if (cnt_q == CNT_W'(STORM_LIMIT - 1)) begin
                    cnt_n = '0;
                    defer = 1'b1;
                end else begin
                    cnt_n  = cnt_q + 1'b1;
                    pend_n = 1'b1;
                end
            end else begin
                cnt_n = '0;
            end
        end
        if (retry_fire && lvl_mode && irr && !remote) pend_n = 1'b1;
        if (line_lo) irr_n = 1'b0;
        if (line_hi) begin
            irr_n = 1'b1;
            if (!lvl_mode) begin
                del_n = 1'b0;
                if (irr) coal_n = 1'b1;
                else     pend_n = 1'b1;
            end else begin
                if (remote) coal_n = 1'b1;
                else        pend_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr       <= 1'b0;
            delivered <= 1'b0;
            remote    <= 1'b0;
            pend      <= 1'b0;
            coalesced <= 1'b0;
            cnt_q     <= '0;
        end else begin
            irr       <= irr_n;
            delivered <= del_n;
            remote    <= rem_n;
            pend      <= pend_n;
            coalesced <= coal_n;
            cnt_q     <= cnt_n;
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(STORM_LIMIT)); // R8
    AST_REMOTE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remote) |-> $past(acc_done && acc_ok && lvl_mode)); // R5
    AST_EDGE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hi && !lvl_mode && irr) |=> coalesced); // R2
    AST_LEVEL_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hi && lvl_mode && remote && !acc_done) |=> coalesced); // R3
endmodule

// File: rtl/irqs_low_arb.sv
module irqs_low_arb #(
    parameter int NPIN = 8,
    localparam int PIN_W = $clog2(NPIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIN-1:0]  req,
    output logic [NPIN-1:0]  grant,
    output logic [PIN_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (req[i]) idx = PIN_W'(i);
        end
        grant = req & (~req + 1'b1);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($onehot0(grant) && grant[idx])); // R11
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ((req & ((NPIN'(1) << idx) - 1'b1)) == '0)); // R11
endmodule

// File: rtl/irqs_retry_timer.sv
module irqs_retry_timer #(
    parameter int RETRY_CYCLES = 2000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic fire
);
    localparam int TW = $clog2(RETRY_CYCLES + 1);

    logic          armed_q;
    logic [TW-1:0] left_q;

    assign fire = armed_q && left_q == '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else if (armed_q) begin
            if (left_q == '0) armed_q <= 1'b0;
            else              left_q  <= left_q - 1'b1;
        end else if (arm) begin
            armed_q <= 1'b1;
            left_q  <= TW'(RETRY_CYCLES - 1);
        end
    end

    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire); // R9
endmodule

// File: rtl/irq_servicer.sv
module irq_servicer
    import irqs_pkg::*;
#(
    parameter int NPIN         = 8,
    parameter int VEC_W        = 8,
    parameter int DEST_W       = 8,
    parameter int HIT_W        = 4,
    parameter int STORM_LIMIT  = 10000,
    parameter int RETRY_CYCLES = 2000000,
    localparam int PIN_W = $clog2(NPIN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPIN-1:0]         line_hi,
    input  logic [NPIN-1:0]         line_lo,
    input  logic [NPIN-1:0]         trig_level,
    input  logic [NPIN-1:0]         pin_mask,
    input  logic [NPIN-1:0]         pin_dest_mode,
    input  logic [NPIN*VEC_W-1:0]   pin_vector,
    input  logic [NPIN*DEST_W-1:0]  pin_dest,
    input  logic [NPIN*3-1:0]       pin_dlv_mode,
    input  logic                    eoi_valid,
    input  logic [VEC_W-1:0]        eoi_vector,
    input  logic                    eoi_level,
    input  logic                    directed_eoi,
    output logic                    msg_valid,
    output logic [PIN_W-1:0]        msg_pin,
    output logic [VEC_W-1:0]        msg_vector,
    output logic [DEST_W-1:0]       msg_dest,
    output logic                    msg_dest_mode,
    output logic [2:0]              msg_dlv_mode,
    output logic                    msg_level,
    input  logic                    msg_accept,
    input  logic [HIT_W-1:0]        msg_hits,
    output logic [NPIN-1:0]         coalesced,
    output logic [NPIN-1:0]         mask_drop,
    output logic [NPIN-1:0]         saved_irr
);
    srv_state_t state_q, state_n;

    logic [NPIN-1:0]  irr, delivered, remote, pend, defer, grant, served, acc_done;
    logic [PIN_W-1:0] idx;
    logic             pick, retry_fire;

    irqs_low_arb #(.NPIN(NPIN)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(pend), .grant(grant), .idx(idx)
    );

    irqs_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(|defer), .fire(retry_fire)
    );

    assign pick   = state_q == S_IDLE && pend != '0;
    assign served = pick ? grant : '0;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        assign acc_done[p] = state_q == S_SEND && msg_accept && msg_pin == PIN_W'(p);
        irqs_pin_slice #(.VEC_W(VEC_W), .STORM_LIMIT(STORM_LIMIT)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .line_hi(line_hi[p]), .line_lo(line_lo[p]),
            .lvl_mode(trig_level[p]), .masked(pin_mask[p]),
            .vector(pin_vector[p*VEC_W +: VEC_W]),
            .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .eoi_level(eoi_level), .directed_eoi(directed_eoi),
            .served(served[p]), .acc_done(acc_done[p]),
            .acc_ok(msg_hits != '0), .retry_fire(retry_fire),
            .irr(irr[p]), .delivered(delivered[p]), .remote(remote[p]),
            .pend(pend[p]), .coalesced(coalesced[p]), .defer(defer[p])
        );
    end

    assign saved_irr = irr & ~delivered;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: if (pick && !pin_mask[idx]) state_n = S_SEND;
            S_SEND: if (msg_accept)             state_n = S_IDLE;
            default:                            state_n = S_IDLE;
        endcase
    end

    // outputs
    assign msg_valid = state_q == S_SEND;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_pin       <= '0;
            msg_vector    <= '0;
            msg_dest      <= '0;
            msg_dest_mode <= 1'b0;
            msg_dlv_mode  <= '0;
            msg_level     <= 1'b0;
            mask_drop     <= '0;
        end else begin
            mask_drop <= (pick && pin_mask[idx]) ? grant : '0;
            if (pick && !pin_mask[idx]) begin
                msg_pin       <= idx;
                msg_vector    <= pin_vector[idx*VEC_W +: VEC_W];
                msg_dest      <= pin_dest[idx*DEST_W +: DEST_W];
                msg_dest_mode <= pin_dest_mode[idx];
                msg_dlv_mode  <= pin_dlv_mode[idx*3 +: 3];
                msg_level     <= trig_level[idx];
            end
        end
    end

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_accept) |=> (msg_valid && $stable(msg_vector) && $stable(msg_pin))); // R12
    AST_MASKED_NOT_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pick && pin_mask[idx]) |=> !msg_valid); // R4
    AST_DROP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_drop)); // R4
endmodule

// File: tb/irq_servicer_bench.sv
module irq_servicer_bench;
    localparam int NPIN = 8, VEC_W = 8, DEST_W = 8, HIT_W = 4;
    localparam int PIN_W = $clog2(NPIN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPIN-1:0] line_hi = '0, line_lo = '0;
    logic [NPIN-1:0] trig_level = 8'b0110_0000;
    logic [NPIN-1:0] pin_mask   = 8'b0000_1000;
    logic [NPIN-1:0] pin_dest_mode = 8'b1010_1010;
    logic [NPIN*VEC_W-1:0]  pin_vector;
    logic [NPIN*DEST_W-1:0] pin_dest;
    logic [NPIN*3-1:0]      pin_dlv_mode;
    logic eoi_valid = 1'b0, eoi_level = 1'b0, directed_eoi = 1'b0;
    logic [VEC_W-1:0] eoi_vector = '0;
    logic msg_valid, msg_dest_mode, msg_level;
    logic [PIN_W-1:0] msg_pin;
    logic [VEC_W-1:0] msg_vector;
    logic [DEST_W-1:0] msg_dest;
    logic [2:0] msg_dlv_mode;
    logic msg_accept = 1'b0;
    logic [HIT_W-1:0] msg_hits = '0;
    logic [NPIN-1:0] coalesced, mask_drop, saved_irr;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    for (genvar p = 0; p < NPIN; p++) begin : g_cfg
        assign pin_vector[p*VEC_W +: VEC_W]   = VEC_W'(8'h20 + p);
        assign pin_dest[p*DEST_W +: DEST_W]   = DEST_W'(8'h10 + p);
        assign pin_dlv_mode[p*3 +: 3]         = 3'(p);
    end

    irq_servicer #(.NPIN(NPIN), .VEC_W(VEC_W), .DEST_W(DEST_W), .HIT_W(HIT_W),
                   .STORM_LIMIT(4), .RETRY_CYCLES(20)) u_irq_servicer (
        .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
        .trig_level(trig_level), .pin_mask(pin_mask), .pin_dest_mode(pin_dest_mode),
        .pin_vector(pin_vector), .pin_dest(pin_dest), .pin_dlv_mode(pin_dlv_mode),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .directed_eoi(directed_eoi), .msg_valid(msg_valid), .msg_pin(msg_pin),
        .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode),
        .msg_dlv_mode(msg_dlv_mode), .msg_level(msg_level), .msg_accept(msg_accept),
        .msg_hits(msg_hits), .coalesced(coalesced), .mask_drop(mask_drop),
        .saved_irr(saved_irr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pulse assert event; returns coalesced and mask_drop seen afterwards
    task automatic raise(input logic [NPIN-1:0] pins, output logic [NPIN-1:0] coal,
                         output logic [NPIN-1:0] drop);
        line_hi = pins;
        @(negedge clk);
        line_hi = '0;
        coal = coalesced;
        @(negedge clk);
        drop = mask_drop;
    endtask

    task automatic lower(input logic [NPIN-1:0] pins);
        line_lo = pins;
        @(negedge clk);
        line_lo = '0;
    endtask

    task automatic eoi(input logic [VEC_W-1:0] v, input logic lvl, input logic dir);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl; directed_eoi = dir;
        @(negedge clk);
        eoi_valid = 1'b0; eoi_level = 1'b0; directed_eoi = 1'b0;
    endtask

    // wait for a message, check its pin and vector, accept it with given hits
    task automatic take(input string req, input int pin, input logic [HIT_W-1:0] hits);
        int n = 0;
        while (!msg_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(req, 32'(msg_valid), 32'd1);
        check(req, 32'(msg_pin), 32'(pin));
        check(req, 32'(msg_vector), 32'h20 + 32'(pin));
        msg_accept = 1'b1; msg_hits = hits;
        @(negedge clk);
        msg_accept = 1'b0; msg_hits = '0;
    endtask

    // expect no message for n cycles
    task automatic quiet(input string req, input int n);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        check("R12 reset valid", 32'(msg_valid), 32'd0);
        check("R10 reset saved", 32'(saved_irr), 32'd0);
        check("R2 reset coalesced", 32'(coalesced), 32'd0);
    endtask

    task automatic t_edge();
        logic [NPIN-1:0] c, d;
        raise(8'h04, c, d);
        check("R10 saved before delivery", 32'(saved_irr[2]), 32'd1);
        check("R12 fields dest", 32'(msg_dest), 32'h12);
        check("R12 fields dlv", 32'(msg_dlv_mode), 32'd2);
        check("R12 fields level", 32'(msg_level), 32'd0);
        take("R5 edge deliver", 2, 4'd1);
        check("R10 delivered edge hidden", 32'(saved_irr[2]), 32'd0);
        check("R2 first edge not merged", 32'(c[2]), 32'd0);
        lower(8'h04);
    endtask

    task automatic t_mask_and_merge();
        logic [NPIN-1:0] c, d;
        raise(8'h08, c, d);
        check("R4 masked drop pulse", 32'(d), 32'h08);
        quiet("R4 masked never sent", 6);
        check("R10 undelivered shows", 32'(saved_irr[3]), 32'd1);
        raise(8'h08, c, d);
        check("R2 edge merge", 32'(c), 32'h08);
        quiet("R2 merged no message", 6);
        lower(8'h08);
        @(negedge clk);
        check("R1 deassert clears", 32'(saved_irr[3]), 32'd0);
    endtask

    task automatic t_zero_hits();
        logic [NPIN-1:0] c, d;
        raise(8'h40, c, d);
        take("R5 level zero hits", 6, 4'd0);
        raise(8'h40, c, d);
        check("R5 no remote after zero hits", 32'(c[6]), 32'd0);
        take("R5 resend after zero hits", 6, 4'd0);
        lower(8'h40);
    endtask

    task automatic t_level_eoi_storm();
        logic [NPIN-1:0] c, d;
        raise(8'h20, c, d);
        take("R5 level deliver", 5, 4'd1);
        raise(8'h20, c, d);
        check("R3 level merge", 32'(c), 32'h20);
        eoi(8'h25, 1'b0, 1'b0);
        quiet("R6 edge eoi ignored", 8);
        raise(8'h20, c, d);
        check("R6 remote kept after edge eoi", 32'(c[5]), 32'd1);
        eoi(8'h25, 1'b1, 1'b1);
        quiet("R6 directed eoi ignored", 8);
        raise(8'h20, c, d);
        check("R6 remote kept when directed", 32'(c[5]), 32'd1);
        eoi(8'h25, 1'b1, 1'b0);
        take("R7 eoi redeliver 1", 5, 4'd1);
        eoi(8'h25, 1'b1, 1'b0);
        take("R7 eoi redeliver 2", 5, 4'd1);
        eoi(8'h25, 1'b1, 1'b0);
        take("R7 eoi redeliver 3", 5, 4'd1);
        eoi(8'h25, 1'b1, 1'b0);
        quiet("R8 storm deferred", 15);
        take("R9 retry redelivers", 5, 4'd1);
        lower(8'h20);
        eoi(8'h25, 1'b1, 1'b0);
        quiet("R7 no redeliver when idle", 8);
        raise(8'h20, c, d);
        check("R7 remote cleared", 32'(c[5]), 32'd0);
        take("R7 fresh deliver", 5, 4'd1);
        eoi(8'h25, 1'b1, 1'b0);
        take("R7 count restarted", 5, 4'd1);
        lower(8'h20);
        eoi(8'h25, 1'b1, 1'b0);
    endtask

    task automatic t_priority();
        logic [NPIN-1:0] c, d;
        raise(8'h12, c, d);
        take("R11 lowest first", 1, 4'd1);
        take("R11 then next", 4, 4'd1);
        lower(8'h12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_mask_and_merge();
        t_zero_hits();
        t_level_eoi_storm();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule